// File: doc/BRIEF.md
# Serial EEPROM Slave Model

This block answers on a four-wire serial bus (mode 0) the way a small byte-addressed EEPROM does. Its storage is an internal RAM array, and it runs from a system clock. The serial clock, select and data-in lines are brought into the system clock domain through synchronizers and edge detectors, so the serial clock must run several times slower than the system clock.

A transfer starts with a one-byte command. Read and write commands then take an address of `ADDR_BYTES` bytes, sent most significant byte first. Reads stream bytes from consecutive locations. A write needs the enable latch to be set. Its data goes into a page buffer and is committed when select goes high. The commit is followed by a busy period of `BUSY_CYCLES` system clocks, which the status byte reports.

The block serves as a stand-in for a real memory part in system-level tests of serial bus masters and driver code. It covers write-enable sequencing, polling for the busy flag and page wrap.

Top module: `spi_eeprom_model`

## Requirements
- R1: The status byte has the busy flag in bit 0, the write-enable latch in bit 1, a two-bit protect field in bits 3:2 and a protect-enable flag in bit 7. Bits 6:4 read 0. After reset the status is 0x00.
- R2: Command 0x06 sets the write-enable latch and command 0x04 clears it, each taking effect with no further bytes.
- R3: Command 0x05 shifts out the current status. Every further byte clocked in the same transfer shifts out a fresh status byte.
- R4: Command 0x03 followed by the address returns the byte at that address, then bytes from the following addresses. After the last location the address wraps to 0. Address bits above the array size are ignored.
- R5: Command 0x02 with the latch set stores the data bytes that follow the address at incrementing addresses. Past the end of a `PAGE_BYTES` page, the address wraps to the start of the same page. When one offset is written twice, the later byte is kept.
- R6: Command 0x02 received while the latch is clear is ignored: memory is unchanged and no busy period starts.
- R7: A write is committed only when select rises after a whole number of bytes and at least one data byte. Otherwise nothing is stored, no busy period starts and the latch keeps its value.
- R8: A committed write sets the busy flag for exactly `BUSY_CYCLES` system clocks. The latch stays set during that period and clears when it ends.
- R9: While busy is set, every command except 0x05 is ignored, including writes, 0x06 and 0x04.
- R10: Command 0x01 with the latch set takes the following byte. Its bits 7 and 3:2 go into the matching status bits, its other bits are dropped, and the latch clears. With the latch clear, the command is ignored.
- R11: Data in is sampled on the rising serial clock edge. Data out changes after the falling edge. The first bit of a reply is valid before the first rising edge of the byte that carries it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the bus master |
| cs_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out, MSB first |

## Verification
The assertions assume the following of the master:
- The serial clock is slower than the system clock by enough margin that every edge passes through the synchronizers.
- Select stays high for several system clocks between transfers, so a busy period always starts while select is high.
- No transfer starts until the busy flag has been polled clear, except where the bench tests that commands are ignored during busy.

The bench holds each serial clock level for six system clocks and leaves twelve clocks between transfers. It polls the status after every committed write. In one directed case it sends a write and a latch-clear command inside the busy window on purpose. Random write addresses and lengths are chosen so that lengths often exceed a page, which exercises page wrap.

// File: rtl/spi_eeprom_model.sv
module spi_eeprom_model #(
  parameter int MEM_BYTES   = 256,
  parameter int PAGE_BYTES  = 16,
  parameter int ADDR_BYTES  = 2,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [2:0] AB3 = 3'(ADDR_BYTES);
  localparam logic [PW-1:0] LAST_IDX = PW'(PAGE_BYTES - 1);

  typedef enum logic [2:0] {OP_NONE, OP_READ, OP_WRITE, OP_RDSR, OP_WRSR} op_t;

  logic [7:0] mem  [MEM_BYTES];
  logic [7:0] pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmask;
  logic [2:0] sck_q, cs_q;
  logic [1:0] mosi_q;
  logic [6:0] sh;
  logic [2:0] bitcnt, nbytes;
  op_t        op;
  logic [AW-1:0] ptr;
  logic [7:0] out_sr;
  logic       load, wel, wpen, sr_ok;
  logic [1:0] bp;
  logic [2:0] sr_new;
  logic [CW-1:0] busy_cnt;
  logic       commit, busy;
  logic [PW-1:0] cidx;
  logic [AW-PW-1:0] wpage;

  wire sel     = !cs_q[1];
  wire rise    = sel && sck_q[1] && !sck_q[2];
  wire fall    = sel && !sck_q[1] && sck_q[2];
  wire cs_up   = cs_q[1] && !cs_q[2];
  wire [7:0] byte_in = {sh, mosi_q[1]};
  wire done    = rise && (bitcnt == 3'd7);
  wire wr_data = done && (op == OP_WRITE) && (nbytes > AB3);
  assign busy  = (busy_cnt != '0);
  wire [7:0] status = {wpen, 3'b000, bp, wel, busy};
  assign miso  = out_sr[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0; cs_q <= '1; mosi_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      cs_q <= {cs_q[1:0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end

  always_ff @(posedge clk) begin
    if (wr_data) pbuf[ptr[PW-1:0]] <= byte_in;
    if (commit && pmask[cidx]) mem[{wpage, cidx}] <= pbuf[cidx];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh <= '0; bitcnt <= '0; nbytes <= '0; op <= OP_NONE; ptr <= '0;
      out_sr <= '0; load <= 1'b0; wel <= 1'b0; wpen <= 1'b0; bp <= '0;
      sr_new <= '0; sr_ok <= 1'b0; busy_cnt <= '0; commit <= 1'b0;
      cidx <= '0; wpage <= '0; pmask <= '0;
    end else begin
      if (busy) begin
        busy_cnt <= busy_cnt - CW'(1);
        if (busy_cnt == CW'(1)) wel <= 1'b0;
      end
      if (commit) begin
        cidx <= cidx + PW'(1);
        if (cidx == LAST_IDX) begin
          commit <= 1'b0;
          pmask <= '0;
        end
      end
      if (cs_up) begin
        if (op == OP_WRITE && bitcnt == '0 && pmask != '0) begin
          busy_cnt <= CW'(BUSY_CYCLES);
          commit <= 1'b1;
          cidx <= '0;
          wpage <= ptr[AW-1:PW];
        end
        if (op == OP_WRSR && bitcnt == '0 && sr_ok) begin
          wpen <= sr_new[2];
          bp <= sr_new[1:0];
          wel <= 1'b0;
        end
        bitcnt <= '0; nbytes <= '0; op <= OP_NONE; load <= 1'b0; sr_ok <= 1'b0;
      end else if (rise) begin
        sh <= byte_in[6:0];
        bitcnt <= bitcnt + 3'd1;
        if (done) begin
          if (nbytes <= AB3) nbytes <= nbytes + 3'd1;
          if (nbytes == '0) begin
            op <= OP_NONE;
            if (byte_in == 8'h05) begin
              op <= OP_RDSR;
              load <= 1'b1;
            end else if (!busy) begin
              case (byte_in)
                8'h06: wel <= 1'b1;
                8'h04: wel <= 1'b0;
                8'h03: op <= OP_READ;
                8'h02: if (wel) begin op <= OP_WRITE; pmask <= '0; end
                8'h01: if (wel) op <= OP_WRSR;
                default: ;
              endcase
            end
          end else begin
            case (op)
              OP_RDSR: load <= 1'b1;
              OP_READ: begin
                if (nbytes <= AB3 && nbytes != AB3) ptr <= AW'({ptr, byte_in});
                if (nbytes == AB3) ptr <= AW'({ptr, byte_in});
                if (nbytes >= AB3) load <= 1'b1;
              end
              OP_WRITE: begin
                if (nbytes <= AB3) ptr <= AW'({ptr, byte_in});
                else begin
                  pmask[ptr[PW-1:0]] <= 1'b1;
                  ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + PW'(1)};
                end
              end
              OP_WRSR: if (nbytes == 3'd1) begin
                sr_new <= {byte_in[7], byte_in[3:2]};
                sr_ok <= 1'b1;
              end
              default: ;
            endcase
          end
        end
      end else if (fall) begin
        if (load) begin
          load <= 1'b0;
          out_sr <= (op == OP_RDSR) ? status : mem[ptr];
          if (op == OP_READ) ptr <= ptr + AW'(1);
        end else begin
          out_sr <= {out_sr[6:0], 1'b0};
        end
      end
    end
endmodule

// File: rtl/spi_eeprom_model_chk.sv
module spi_eeprom_model_chk #(
  parameter int BUSY_CYCLES = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic busy,
  input logic wel
);
  int run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= 0;
    else if (!busy) run <= 0;
    else run <= run + 1;

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run == BUSY_CYCLES); // R8
  AST_WEL_CLEARED_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel); // R8
  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wel); // R6
  AST_START_WHILE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cs_n); // R7
  AST_WEL_FROZEN_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(wel)); // R9
endmodule

bind spi_eeprom_model spi_eeprom_model_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .busy(busy), .wel(wel)
);

// File: tb/spi_eeprom_model_test.sv
module spi_eeprom_model_test;
  localparam int MEM = 256, PAGE = 16, AB = 2, BUSY = 1000, HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [7:0] model [MEM];
  logic [7:0] wbuf [32];
  logic wel_m = 1'b0, wpen_m = 1'b0;
  logic [1:0] bp_m = 2'b00;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  spi_eeprom_model #(.MEM_BYTES(MEM), .PAGE_BYTES(PAGE), .ADDR_BYTES(AB), .BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input logic b);
    return {wpen_m, 3'b000, bp_m, wel_m, b};
  endfunction

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] d;
    xfer(b, d);
  endtask

  task automatic bits(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic send_addr(input int a);
    for (int k = AB - 1; k >= 0; k--) send(8'(a >> (8 * k)));
  endtask

  task automatic cmd1(input logic [7:0] b);
    sel(); send(b); desel();
  endtask

  task automatic read_status(output logic [7:0] s);
    sel(); send(8'h05); xfer(8'h00, s); desel();
  endtask

  task automatic wait_ready(input string req, input bit first);
    logic [7:0] s;
    int n;
    read_status(s);
    if (first) check({req, " busy right after commit"}, s, exp_status(1'b1));
    n = 0;
    while (s[0] && n < 100) begin
      read_status(s);
      n++;
    end
    wel_m = 1'b0;
    check({req, " idle and latch cleared"}, s, exp_status(1'b0));
  endtask

  task automatic model_write(input int addr, input int len);
    int base, off;
    base = (addr % MEM) - (addr % PAGE);
    off = addr % PAGE;
    for (int i = 0; i < len; i++) model[base + ((off + i) % PAGE)] = wbuf[i];
  endtask

  task automatic do_write(input int addr, input int len, input string req);
    sel(); send(8'h02); send_addr(addr);
    for (int i = 0; i < len; i++) send(wbuf[i]);
    desel();
    if (wel_m) begin
      model_write(addr, len);
      wait_ready(req, 1'b1);
    end
  endtask

  task automatic check_read(input int addr, input int len, input string req);
    logic [7:0] d;
    sel(); send(8'h03); send_addr(addr);
    for (int i = 0; i < len; i++) begin
      xfer(8'h00, d);
      check(req, d, model[(addr + i) % MEM]);
    end
    desel();
  endtask

  task automatic wren();
    cmd1(8'h06);
    wel_m = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hung expected finished");
    summary();
  end

  initial begin
    logic [7:0] s;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    read_status(s);
    check("R1 reset status", s, 8'h00);
    check("R1 miso idle", miso, 0);

    wren();
    read_status(s);
    check("R2 latch set by 0x06", s, 8'h02);
    cmd1(8'h04); wel_m = 1'b0;
    read_status(s);
    check("R2 latch cleared by 0x04", s, 8'h00);

    for (int p = 0; p < MEM / PAGE; p++) begin
      for (int i = 0; i < PAGE; i++) wbuf[i] = 8'($urandom);
      wren();
      do_write(p * PAGE, PAGE, "R8");
    end
    check_read(0, MEM, "R4 full sequential read");
    check_read(MEM - 5, 12, "R4 wrap to address 0");
    check_read(16'h1305, 3, "R4 upper address bits ignored");

    for (int i = 0; i < 20; i++) wbuf[i] = 8'(8'hC0 + i);
    wren();
    do_write(16'h002A, 20, "R5");
    check_read(16'h0020, PAGE, "R5 page wrap on write");

    for (int i = 0; i < 4; i++) wbuf[i] = 8'hEE;
    do_write(16'h0050, 4, "R6");
    check_read(16'h0050, 4, "R6 write without latch ignored");
    read_status(s);
    check("R6 no busy without latch", s, exp_status(1'b0));

    wren();
    sel(); send(8'h02); send_addr(16'h0060); send(8'h11); send(8'h22); bits(3); desel();
    check_read(16'h0060, 2, "R7 partial byte discards write");
    read_status(s);
    check("R7 latch kept and idle after partial", s, 8'h02);
    sel(); send(8'h02); send_addr(16'h0061); desel();
    read_status(s);
    check("R7 no data bytes starts nothing", s, 8'h02);

    wbuf[0] = 8'hA5;
    sel(); send(8'h02); send_addr(16'h0070); send(wbuf[0]); desel();
    model_write(16'h0070, 1);
    sel(); send(8'h02); send_addr(16'h0090); send(8'h5A); desel();
    cmd1(8'h04);
    read_status(s);
    check("R9 commands ignored while busy", s, 8'h03);
    wait_ready("R9", 1'b0);
    check_read(16'h0090, 1, "R9 write during busy dropped");
    check_read(16'h0070, 1, "R9 first write stored");

    sel(); send(8'h01); send(8'h8C); desel();
    read_status(s);
    check("R10 status write without latch ignored", s, 8'h00);
    wren();
    sel(); send(8'h01); send(8'hFF); desel();
    wel_m = 1'b0; wpen_m = 1'b1; bp_m = 2'b11;
    read_status(s);
    check("R10 status bits stored, latch cleared", s, 8'h8C);
    wren();
    sel(); send(8'h01); send(8'h00); desel();
    wel_m = 1'b0; wpen_m = 1'b0; bp_m = 2'b00;
    read_status(s);
    check("R10 status bits cleared", s, 8'h00);

    wren();
    sel(); send(8'h05);
    for (int i = 0; i < 3; i++) begin
      xfer(8'h00, s);
      check("R3 repeated status byte", s, 8'h02);
    end
    desel();
    cmd1(8'h04); wel_m = 1'b0;

    for (int it = 0; it < 10; it++) begin
      int a, n;
      a = $urandom_range(0, MEM - 1);
      n = $urandom_range(1, PAGE + 4);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wren();
      do_write(a, n, "R5");
      check_read(a - (a % PAGE), PAGE, "R5 R11 random page write");
    end

    summary();
  end
endmodule